// File: doc/BRIEF.md
# Stream Formatter Row with Butterfly Shuffle

This block is one row of a stream formatter. It takes two 128-bit operand streams, split into eight 16-bit lanes, together with a beat ID and a valid flag. An input crossbar chooses, for every lane, which input lane feeds its first operand and which feeds its second. Eight small ALUs then compute on their operands. Each ALU can add, subtract, shift, or take an absolute value. A shuffle network after the ALUs can swap lanes in butterfly fashion, or it can be bypassed. Data moves only forward through pipeline registers. Lanes never pass data to each other inside the row.

Each lane holds four stored configurations. The crossbar holds sixteen. The crossbar configuration also carries the shuffle mode. For each beat, two selectors pick the active configurations, and a simple write port fills the stores. The row produces one beat per clock. The result appears three cycles after its inputs, with the ID and valid flag carried along in step.

Top module: `fmt_row`

## Requirements
- R1: `out_valid` and `out_id` equal the `in_valid` and `in_id` presented three clock edges earlier.
- R2: Crossbar routing comes from the crossbar word. Its bits [3i+2:3i] give the input lane that feeds operand A of lane i, taken from `in_a`. Its bits [24+3i+2:24+3i] give the input lane that feeds operand B of lane i, taken from `in_b`. Lane k of a bus occupies bits [16k+15:16k].
- R3: The lane configuration is 7 bits wide. Op code bits [1:0] = 0 gives A+B and op code 1 gives A−B, both modulo 2^16.
- R4: Op code 2 is a shift of A by bits [6:3]. Bit 2 = 0 selects a logical left shift, and bit 2 = 1 selects an arithmetic right shift.
- R5: Op code 3 returns the absolute value of A, read as a signed number. The input 0x8000 saturates to 0x7FFF.
- R6: Crossbar word bits [49:48] select the shuffle. Mode 0 is bypass. Modes 1, 2 and 3 place ALU result lane i^d on output lane i, with d = 1, 2 and 4.
- R7: `pe_sel` and `xb_sel` are captured only when `in_valid` is high. Data keeps flowing on bubble cycles, and bubble beats are computed with the last captured selectors.
- R8: Each lane has its own four configurations, all chosen by the common `pe_sel`. `xb_sel` chooses one of the sixteen crossbar words.
- R9: A write with `cfg_we` high goes to the crossbar slot `cfg_slot` when `cfg_xb`=1, using all of `cfg_data`. When `cfg_xb`=0 it goes to lane `cfg_lane` at slot `cfg_slot[1:0]`, using `cfg_data[6:0]`. The write applies to every beat presented from that cycle on.
- R10: After reset, `out_valid` and `out_data` are 0 and both selectors are 0. Every lane slot holds add (all zero). Every crossbar slot holds identity routing (lane i from lane i) with bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat valid |
| in_id | input | 4 | Beat ID |
| in_a | input | 128 | Operand stream A, eight 16-bit lanes |
| in_b | input | 128 | Operand stream B, eight 16-bit lanes |
| pe_sel | input | 2 | Lane configuration selector |
| xb_sel | input | 4 | Crossbar configuration selector |
| cfg_we | input | 1 | Configuration write enable |
| cfg_xb | input | 1 | Write target: 1 crossbar, 0 lane |
| cfg_lane | input | 3 | Lane index for lane writes |
| cfg_slot | input | 4 | Slot index |
| cfg_data | input | 50 | Configuration word |
| out_valid | output | 1 | Result valid |
| out_id | output | 4 | Result ID |
| out_data | output | 128 | Result, eight 16-bit lanes |

## Verification
The bench sweeps every pair of lane and crossbar selectors over random and extreme data. It also sweeps all 32 combinations of shift amount and direction. A shuffle that used the wrong XOR distance would leave lanes misplaced. A right shift that filled with zeros would show up on negative inputs. An absolute value that wrapped 0x8000 to itself would come out negative. Bubble cycles carry new selector values together with live data. A design that captured selectors without checking valid would compute those beats with the wrong configuration. A configuration write followed at once by a beat that uses it exposes a store that updates one cycle too late.

// File: rtl/fmt_row.sv
`timescale 1ns/1ps
module fmt_row #(
  parameter int LANES    = 8,
  parameter int W        = 16,
  parameter int IDW      = 4,
  parameter int PE_SLOTS = 4,
  parameter int XB_SLOTS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [IDW-1:0]           in_id,
  input  logic [LANES*W-1:0]       in_a,
  input  logic [LANES*W-1:0]       in_b,
  input  logic [$clog2(PE_SLOTS)-1:0] pe_sel,
  input  logic [$clog2(XB_SLOTS)-1:0] xb_sel,
  input  logic                     cfg_we,
  input  logic                     cfg_xb,
  input  logic [$clog2(LANES)-1:0] cfg_lane,
  input  logic [$clog2(XB_SLOTS)-1:0] cfg_slot,
  input  logic [2*LANES*$clog2(LANES)+1:0] cfg_data,
  output logic                     out_valid,
  output logic [IDW-1:0]           out_id,
  output logic [LANES*W-1:0]       out_data
);
  localparam int LW  = $clog2(LANES);
  localparam int PSW = $clog2(PE_SLOTS);
  localparam int XSW = $clog2(XB_SLOTS);
  localparam int SHW = $clog2(W);
  localparam int PCW = 3 + SHW;
  localparam int XCW = 2*LANES*LW + 2;
  localparam int BW  = LANES*W;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  function automatic logic [XCW-1:0] ident_word();
    logic [XCW-1:0] w;
    w = '0;
    for (int i = 0; i < LANES; i++) begin
      w[i*LW +: LW]         = LW'(i);
      w[(LANES+i)*LW +: LW] = LW'(i);
    end
    return w;
  endfunction

  logic [PCW-1:0] pe_cfg [LANES][PE_SLOTS];
  logic [XCW-1:0] xb_cfg [XB_SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int l = 0; l < LANES; l++)
        for (int s = 0; s < PE_SLOTS; s++) pe_cfg[l][s] <= '0;
      for (int s = 0; s < XB_SLOTS; s++) xb_cfg[s] <= ident_word();
    end else if (cfg_we) begin
      if (cfg_xb) xb_cfg[cfg_slot] <= cfg_data;
      else        pe_cfg[cfg_lane][cfg_slot[PSW-1:0]] <= cfg_data[PCW-1:0];
    end
  end

  logic           v1, v2;
  logic [IDW-1:0] id1, id2;
  logic [BW-1:0]  a1, b1, r2, r_nx, shf;
  logic [PSW-1:0] ps_q;
  logic [XSW-1:0] xs_q;
  logic [1:0]     m2;
  logic [XCW-1:0] xw;

  assign xw = xb_cfg[xs_q];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LW-1:0]  sa, sb, src;
    logic [W-1:0]   oa, ob, res;
    logic [PCW-1:0] pc;
    logic [SHW-1:0] sh;
    assign sa = xw[i*LW +: LW];
    assign sb = xw[(LANES+i)*LW +: LW];
    assign oa = a1[sa*W +: W];
    assign ob = b1[sb*W +: W];
    assign pc = pe_cfg[i][ps_q];
    assign sh = pc[PCW-1:3];
    always_comb begin
      case (pc[1:0])
        2'd0:    res = oa + ob;
        2'd1:    res = oa - ob;
        2'd2:    res = pc[2] ? W'($signed(oa) >>> sh) : W'(oa << sh);
        default: res = (oa == MINV) ? MAXV : (oa[W-1] ? W'(-oa) : oa);
      endcase
    end
    assign r_nx[i*W +: W] = res;
    assign src = (m2 == 2'd0) ? LW'(i) : (LW'(i) ^ LW'(1 << (m2 - 2'd1)));
    assign shf[i*W +: W] = r2[src*W +: W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {v1, v2, out_valid} <= '0;
      {id1, id2, out_id}  <= '0;
      {a1, b1, r2, out_data} <= '0;
      ps_q <= '0;
      xs_q <= '0;
      m2   <= '0;
    end else begin
      v1  <= in_valid;
      id1 <= in_id;
      a1  <= in_a;
      b1  <= in_b;
      if (in_valid) begin
        ps_q <= pe_sel;
        xs_q <= xb_sel;
      end
      v2  <= v1;
      id2 <= id1;
      r2  <= r_nx;
      m2  <= xw[XCW-1 -: 2];
      out_valid <= v2;
      out_id    <= id2;
      out_data  <= shf;
    end
  end
endmodule

module fmt_row_chk #(
  parameter int W   = 16,
  parameter int BW  = 128,
  parameter int IDW = 4,
  parameter int PSW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [IDW-1:0] in_id,
  input logic [PSW-1:0] pe_sel,
  input logic           out_valid,
  input logic [IDW-1:0] out_id,
  input logic [BW-1:0]  out_data,
  input logic [PSW-1:0] ps_q,
  input logic [1:0]     m2,
  input logic [BW-1:0]  r2
);
  logic [1:0] cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (cnt != 2'd3) cnt <= cnt + 2'd1;
  end

  p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd3) |-> out_valid == $past(in_valid, 3));
  p_id_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 2'd3 && out_valid) |-> out_id == $past(in_id, 3));
  p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(ps_q));
  p_sel_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ps_q == $past(pe_sel));
  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m2 == 2'd0) |=> out_data == $past(r2));
  p_swap1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m2 == 2'd1) |=> out_data[W-1:0] == $past(r2[2*W-1:W]));
endmodule

bind fmt_row fmt_row_chk #(.W(W), .BW(BW), .IDW(IDW), .PSW(PSW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id), .pe_sel(pe_sel),
  .out_valid(out_valid), .out_id(out_id), .out_data(out_data),
  .ps_q(ps_q), .m2(m2), .r2(r2)
);

// File: tb/fmt_row_tb_top.sv
`timescale 1ns/1ps
module fmt_row_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic         in_valid = 0;
  logic [3:0]   in_id = 0;
  logic [127:0] in_a = 0, in_b = 0;
  logic [1:0]   pe_sel = 0;
  logic [3:0]   xb_sel = 0;
  logic         cfg_we = 0, cfg_xb = 0;
  logic [2:0]   cfg_lane = 0;
  logic [3:0]   cfg_slot = 0;
  logic [49:0]  cfg_data = 0;
  logic         out_valid;
  logic [3:0]   out_id;
  logic [127:0] out_data;

  fmt_row dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id),
    .in_a(in_a), .in_b(in_b), .pe_sel(pe_sel), .xb_sel(xb_sel),
    .cfg_we(cfg_we), .cfg_xb(cfg_xb), .cfg_lane(cfg_lane), .cfg_slot(cfg_slot),
    .cfg_data(cfg_data), .out_valid(out_valid), .out_id(out_id), .out_data(out_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R10";
  logic [31:0] seed = 32'h1234_5678;

  logic [49:0]  sh_xb [16];
  logic [6:0]   sh_pe [8][4];
  logic [1:0]   hold_ps = 0;
  logic [3:0]   hold_xs = 0;
  logic         e_v  [3];
  logic [3:0]   e_id [3];
  logic [127:0] e_d  [3];
  int n = 0;

  function automatic logic [31:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  function automatic logic [15:0] alu(input logic [6:0] pc, input logic [15:0] a, input logic [15:0] b);
    logic signed [15:0] sa;
    sa = a;
    case (pc[1:0])
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return pc[2] ? 16'(sa >>> pc[6:3]) : 16'(a << pc[6:3]);
      default: begin
        if (a == 16'h8000) return 16'h7fff;
        return a[15] ? 16'(0 - a) : a;
      end
    endcase
  endfunction

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b);
    logic [15:0] r [8];
    logic [49:0] w;
    logic [127:0] o;
    int d;
    w = sh_xb[hold_xs];
    for (int i = 0; i < 8; i++) begin
      int ka, kb;
      ka = int'(w[3*i +: 3]);
      kb = int'(w[24 + 3*i +: 3]);
      r[i] = alu(sh_pe[i][hold_ps], a[16*ka +: 16], b[16*kb +: 16]);
    end
    d = (w[49:48] == 2'd0) ? 0 : (1 << (int'(w[49:48]) - 1));
    for (int i = 0; i < 8; i++) o[16*i +: 16] = r[i ^ d];
    return o;
  endfunction

  function automatic logic [49:0] xbw(input int s);
    logic [49:0] w;
    w = '0;
    for (int i = 0; i < 8; i++) begin
      w[3*i +: 3]      = 3'((3*i + s) % 8);
      w[24 + 3*i +: 3] = 3'((i + 5*s) % 8);
    end
    w[49:48] = 2'(s % 4);
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    int k;
    if (cfg_we) begin
      if (cfg_xb) sh_xb[cfg_slot] = cfg_data;
      else sh_pe[cfg_lane][cfg_slot[1:0]] = cfg_data[6:0];
    end
    if (in_valid) begin
      hold_ps = pe_sel;
      hold_xs = xb_sel;
    end
    k = n % 3;
    e_v[k]  = in_valid;
    e_id[k] = in_id;
    e_d[k]  = model(in_a, in_b);
    @(posedge clk);
    @(negedge clk);
    k = (n + 1) % 3;
    chk(out_valid == e_v[k], "R1 valid", 128'(out_valid), 128'(e_v[k]));
    if (e_v[k]) chk(out_id == e_id[k], "R1 id", 128'(out_id), 128'(e_id[k]));
    chk(out_data == e_d[k], cur_req, out_data, e_d[k]);
    n++;
    cfg_we = 0;
  endtask

  function automatic logic [15:0] corner(input int c);
    case (c % 8)
      0: return 16'h8000;
      1: return 16'h7fff;
      2: return 16'hffff;
      3: return 16'h0000;
      4: return 16'h0001;
      5: return 16'h8001;
      6: return 16'hc000;
      default: return 16'h4321;
    endcase
  endfunction

  task automatic beat(input bit v, input logic [1:0] ps, input logic [3:0] xs, input bit corners);
    in_valid = v;
    in_id    = 4'(n);
    pe_sel   = ps;
    xb_sel   = xs;
    for (int i = 0; i < 4; i++) begin
      in_a[32*i +: 32] = rnd();
      in_b[32*i +: 32] = rnd();
    end
    if (corners)
      for (int i = 0; i < 8; i++) begin
        in_a[16*i +: 16] = corner(int'(rnd() % 8));
        in_b[16*i +: 16] = corner(int'(rnd() % 8));
      end
    step();
  endtask

  task automatic wr(input bit xb, input int lane, input int slot, input logic [49:0] d);
    in_valid = 0;
    cfg_we = 1;
    cfg_xb = xb;
    cfg_lane = 3'(lane);
    cfg_slot = 4'(slot);
    cfg_data = d;
    step();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 16; s++) begin
      sh_xb[s] = '0;
      for (int i = 0; i < 8; i++) begin
        sh_xb[s][3*i +: 3] = 3'(i);
        sh_xb[s][24 + 3*i +: 3] = 3'(i);
      end
    end
    for (int l = 0; l < 8; l++) for (int s = 0; s < 4; s++) sh_pe[l][s] = '0;
    for (int k = 0; k < 3; k++) begin e_v[k] = 0; e_id[k] = 0; e_d[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R10 reset valid", 128'(out_valid), 128'(0));
    chk(out_data == '0, "R10 reset data", out_data, 128'(0));
    rst_n = 1;

    cur_req = "R10 defaults";
    for (int j = 0; j < 6; j++) beat(1'b1, 2'(j), 4'(j), j[0]);

    cur_req = "R9 write";
    for (int l = 0; l < 8; l++) begin
      wr(0, l, 0, 50'(7'b000_0000));
      wr(0, l, 1, 50'(7'b000_0001));
      wr(0, l, 2, 50'({4'(2*l + 1), l[0], 2'd2}));
      wr(0, l, 3, 50'(7'b000_0011));
    end
    for (int s = 0; s < 16; s++) wr(1, 0, s, xbw(s));

    for (int p = 0; p < 4; p++) begin
      cur_req = (p < 2) ? "R3 R2 R6 R8" : (p == 2) ? "R4 R2 R6 R8" : "R5 R2 R6 R8";
      for (int s = 0; s < 16; s++)
        for (int j = 0; j < 4; j++) beat(1'b1, 2'(p), 4'(s), j[0]);
    end

    cur_req = "R4 shift sweep";
    for (int sh = 0; sh < 16; sh++)
      for (int dir = 0; dir < 2; dir++) begin
        for (int l = 0; l < 8; l++) wr(0, l, 2, 50'({4'(sh), 1'(dir), 2'd2}));
        for (int j = 0; j < 3; j++) beat(1'b1, 2'd2, 4'(j * 5), j != 1);
      end

    cur_req = "R5 abs corners";
    for (int j = 0; j < 24; j++) beat(1'b1, 2'd3, 4'(j % 16), 1'b1);

    cur_req = "R7 bubbles";
    for (int j = 0; j < 20; j++) begin
      beat(1'b1, 2'(j % 4), 4'(j), j[1]);
      beat(1'b0, 2'(3 - j % 4), 4'(15 - j), j[0]);
      beat(1'b0, 2'(j + 1), 4'(j + 7), 1'b0);
    end

    cur_req = "R9 immediate use";
    for (int j = 0; j < 8; j++) begin
      wr(1, 0, 7, xbw(j + 3));
      beat(1'b1, 2'd1, 4'd7, 1'b0);
      wr(0, j, 1, 50'(7'b000_0011));
      beat(1'b1, 2'd1, 4'd7, 1'b1);
    end

    cur_req = "R1 drain";
    for (int j = 0; j < 4; j++) beat(1'b0, 2'd0, 4'd0, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule